// File: doc/BRIEF.md
# Memory Request Tracker with Response Reordering

This block sits between the instruction issue stage of a compute pipeline and its global memory port. Memory requests arrive in program order, each carrying a sequence tag and an operation kind. The block passes a request downstream in the same cycle it accepts it, provided the in-flight budget for that kind of request still has room. Otherwise it holds the request at the head of the issue queue until a completion frees a slot.

Responses come back from memory tagged and in any order. A mode input picks how they reach register writeback. In ordered mode, every load, store and atomic reserves a slot in a circular reorder queue when it is issued. A response only marks its slot complete, and writeback is offered strictly from the oldest slot. In out-of-order mode, responses go straight into one of two return queues: one for loads and atomics, one for stores. Writeback takes from the load queue first.

A completion happens when writeback is offered, the downstream bus accepts it and the register-file port is free. Each completion returns one unit of in-flight budget. The mode input is only taken in while nothing is outstanding. Protocol violations raise a sticky error flag that stays set until reset.

Top module: `memreq_tracker`

## Requirements
- R1: Operation codes are 0 load, 1 store, 2 atomic, 3 fence. Loads and atomics share one in-flight counter and stores have a separate one. Each counter allows at most LIMIT requests in flight.
- R2: When the head request's counter is at LIMIT, `req_ready` is low and `iss_valid` stays low until a completion of that class. A fence is never stalled and never counted.
- R3: An accepted request appears on `iss_valid`/`iss_tag`/`iss_op` in the same cycle.
- R4: In ordered mode, writeback follows issue order whatever the response order. The oldest entry is offered only after its response has arrived.
- R5: A fence reserves no reorder slot and needs no response, so it never blocks later writebacks.
- R6: In ordered mode, a response whose tag matches no pending entry sets `err`, and `err` stays set until reset.
- R7: In out-of-order mode, loads and atomics return through one queue and stores through another. When both queues hold entries, the load queue's head is offered first. Each queue keeps its arrival order.
- R8: In out-of-order mode, `rsp_ready` is low when the queue a response targets holds RET_DEPTH entries. A response bound for the other queue is still accepted.
- R9: `wb_valid` is only high while `port_free` is high. At most one completion occurs per cycle, and a completion returns one unit to its counter.
- R10: The mode input takes effect only in a cycle where no request is outstanding or being presented. A change made while work is outstanding waits until the block drains.
- R11: In out-of-order mode, a completion whose counter is already zero sets `err`, and so does a fence response.
- R12: After reset: `req_ready` high, `rsp_ready` high, `wb_valid` low, `err` low, with ordered mode in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ooo_mode | input | 1 | 1 selects out-of-order delivery, 0 ordered |
| req_valid | input | 1 | Head request of the issue queue is valid |
| req_tag | input | TAG_W | Sequence tag of the head request |
| req_op | input | 2 | Operation code of the head request |
| req_ready | output | 1 | Head request is accepted this cycle if valid |
| iss_valid | output | 1 | Request issued downstream |
| iss_tag | output | TAG_W | Tag of the issued request |
| iss_op | output | 2 | Operation code of the issued request |
| rsp_valid | input | 1 | Memory response valid |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_op | input | 2 | Operation code of the response |
| rsp_ready | output | 1 | Response accepted this cycle if valid |
| port_free | input | 1 | Register-file write port available |
| wb_ready | input | 1 | Writeback bus accepts |
| wb_valid | output | 1 | Writeback offered |
| wb_tag | output | TAG_W | Tag of the offered writeback |
| wb_op | output | 2 | Operation code of the offered writeback |
| err | output | 1 | Sticky protocol error |

## Verification
The bench returns responses in reverse issue order. A reorder queue that retired by response arrival instead of age would hand back the youngest tag first. It fills the load counter with a mix of loads and atomics and then presents a store and a fence. A design that shared one counter, or counted fences, would stall them. In out-of-order mode it fills the load return queue while a store response waits. It also checks that the load head beats an earlier-arrived store, so a shared or wrong-priority queue returns the wrong tag. Finally, it flips the mode with a load outstanding. A design that switched at once would hold back a finished store behind it, or strand the load in the wrong structure.

// File: rtl/memreq_pkg.sv
package memreq_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_ATOMIC = 2'd2,
        OP_FENCE  = 2'd3
    } mem_op_e;

    localparam int NUM_CLASSES = 2;
    localparam int CLS_READ    = 0;
    localparam int CLS_WRITE   = 1;

    function automatic logic op_is_read(input logic [1:0] op);
        return (op == OP_LOAD) || (op == OP_ATOMIC);
    endfunction

    function automatic logic op_is_write(input logic [1:0] op);
        return op == OP_STORE;
    endfunction

endpackage

// File: rtl/memreq_inflight.sv
module memreq_inflight #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic room,
    output logic nonzero,
    output logic underflow
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] n;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       dec_eff;

    always_comb begin
        s_d       = s_q;
        underflow = dec && (s_q.n == '0);
        dec_eff   = dec && (s_q.n != '0);
        case ({inc, dec_eff})
            2'b10:   s_d.n = s_q.n + 1'b1;
            2'b01:   s_d.n = s_q.n - 1'b1;
            default: s_d.n = s_q.n;
        endcase
    end

    assign room    = int'(s_q.n) < LIMIT;
    assign nonzero = s_q.n != '0;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: the count never exceeds its cap
    assert_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.n) <= LIMIT);

    // R2: at the cap and with no completion, the count cannot move
    assert_hold_at_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(s_q.n) == LIMIT && !dec) |=> int'(s_q.n) == LIMIT);

endmodule

// File: rtl/memreq_retq.sv
module memreq_retq #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [1:0]       push_op,
    input  logic             pop,
    output logic             full,
    output logic             empty,
    output logic [TAG_W-1:0] head_tag,
    output logic [1:0]       head_op
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [DEPTH-1:0][1:0]       op;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } q_state_t;

    q_state_t s_d, s_q;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign full     = int'(s_q.cnt) == DEPTH;
    assign empty    = s_q.cnt == '0;
    assign head_tag = s_q.tag[s_q.rd];
    assign head_op  = s_q.op[s_q.rd];
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.tag[s_q.wr] = push_tag;
            s_d.op[s_q.wr]  = push_op;
            s_d.wr          = bump(s_q.wr);
        end
        if (do_pop) s_d.rd = bump(s_q.rd);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: nothing is pushed into a full return queue
    assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: a completion never pops an empty queue
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/memreq_rob.sv
module memreq_rob #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [1:0]       alloc_op,
    input  logic             mark,
    input  logic [TAG_W-1:0] mark_tag,
    input  logic             retire,
    output logic             miss,
    output logic             full,
    output logic             empty,
    output logic             head_done,
    output logic [TAG_W-1:0] head_tag,
    output logic [1:0]       head_op
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0]            done;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [DEPTH-1:0][1:0]       op;
        logic [PTR_W-1:0]            head;
        logic [PTR_W-1:0]            tail;
        logic [CNT_W-1:0]            cnt;
    } rob_state_t;

    rob_state_t       s_d, s_q;
    logic             found;
    logic [PTR_W-1:0] hit_idx;
    logic             do_alloc, do_retire;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign full      = int'(s_q.cnt) == DEPTH;
    assign empty     = s_q.cnt == '0;
    assign head_done = s_q.vld[s_q.head] && s_q.done[s_q.head];
    assign head_tag  = s_q.tag[s_q.head];
    assign head_op   = s_q.op[s_q.head];
    assign do_alloc  = alloc && !full;
    assign do_retire = retire && head_done;

    // tag lookup over pending (valid, not yet done) slots
    always_comb begin
        found   = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && s_q.vld[i] && !s_q.done[i] && s_q.tag[i] == mark_tag) begin
                found   = 1'b1;
                hit_idx = PTR_W'(i);
            end
        end
    end

    assign miss = mark && !found;

    always_comb begin
        s_d = s_q;
        if (mark && found) s_d.done[hit_idx] = 1'b1;
        if (do_retire) begin
            s_d.vld[s_q.head]  = 1'b0;
            s_d.done[s_q.head] = 1'b0;
            s_d.head           = bump(s_q.head);
        end
        if (do_alloc) begin
            s_d.vld[s_q.tail]  = 1'b1;
            s_d.done[s_q.tail] = 1'b0;
            s_d.tag[s_q.tail]  = alloc_tag;
            s_d.op[s_q.tail]   = alloc_op;
            s_d.tail           = bump(s_q.tail);
        end
        case ({do_alloc, do_retire})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: a reservation always finds a free slot
    assert_alloc_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);

    // R4: only a completed oldest slot is retired
    assert_retire_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> head_done);

endmodule

// File: rtl/memreq_tracker.sv
module memreq_tracker
    import memreq_pkg::*;
#(
    parameter int TAG_W     = 8,
    parameter int LIMIT     = 4,
    parameter int RET_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ooo_mode,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [1:0]       req_op,
    output logic             req_ready,
    output logic             iss_valid,
    output logic [TAG_W-1:0] iss_tag,
    output logic [1:0]       iss_op,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic [1:0]       rsp_op,
    output logic             rsp_ready,
    input  logic             port_free,
    input  logic             wb_ready,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag,
    output logic [1:0]       wb_op,
    output logic             err
);
    localparam int ROB_DEPTH = 2 * LIMIT;

    typedef struct packed {
        logic ooo;
        logic err;
    } top_state_t;

    top_state_t t_d, t_q;

    logic [NUM_CLASSES-1:0] cls_inc, cls_dec, cls_room, cls_nz, cls_under;
    logic                   issue, rsp_fire, wb_fire, idle;
    logic                   rob_alloc, rob_mark, rob_retire, rob_miss;
    logic                   rob_full, rob_empty, rob_head_done;
    logic [TAG_W-1:0]       rob_head_tag;
    logic [1:0]             rob_head_op;
    logic                   rq_push, rq_pop, rq_full, rq_empty;
    logic                   wq_push, wq_pop, wq_full, wq_empty;
    logic [TAG_W-1:0]       rq_head_tag, wq_head_tag;
    logic [1:0]             rq_head_op, wq_head_op;
    logic                   cand;

    // ---------------- in-flight budget, one counter per class ----------------
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        memreq_inflight #(.LIMIT(LIMIT)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (cls_inc[c]),
            .dec       (cls_dec[c]),
            .room      (cls_room[c]),
            .nonzero   (cls_nz[c]),
            .underflow (cls_under[c])
        );
    end

    // ---------------- issue ----------------
    always_comb begin
        if (op_is_read(req_op))       req_ready = cls_room[CLS_READ];
        else if (op_is_write(req_op)) req_ready = cls_room[CLS_WRITE];
        else                          req_ready = 1'b1;
    end

    assign issue     = req_valid && req_ready;
    assign iss_valid = issue;
    assign iss_tag   = req_tag;
    assign iss_op    = req_op;

    assign cls_inc[CLS_READ]  = issue && op_is_read(req_op);
    assign cls_inc[CLS_WRITE] = issue && op_is_write(req_op);
    assign rob_alloc          = issue && !t_q.ooo && (req_op != OP_FENCE);

    // ---------------- response intake ----------------
    always_comb begin
        if (!t_q.ooo)                 rsp_ready = 1'b1;
        else if (op_is_read(rsp_op))  rsp_ready = !rq_full;
        else if (op_is_write(rsp_op)) rsp_ready = !wq_full;
        else                          rsp_ready = 1'b1;
    end

    assign rsp_fire = rsp_valid && rsp_ready;
    assign rob_mark = rsp_fire && !t_q.ooo;
    assign rq_push  = rsp_fire && t_q.ooo && op_is_read(rsp_op);
    assign wq_push  = rsp_fire && t_q.ooo && op_is_write(rsp_op);

    // ---------------- writeback selection ----------------
    always_comb begin
        if (t_q.ooo) begin
            cand   = !rq_empty || !wq_empty;
            wb_tag = !rq_empty ? rq_head_tag : wq_head_tag;
            wb_op  = !rq_empty ? rq_head_op  : wq_head_op;
        end else begin
            cand   = rob_head_done;
            wb_tag = rob_head_tag;
            wb_op  = rob_head_op;
        end
    end

    assign wb_valid   = cand && port_free;
    assign wb_fire    = wb_valid && wb_ready;
    assign rob_retire = wb_fire && !t_q.ooo;
    assign rq_pop     = wb_fire && t_q.ooo && !rq_empty;
    assign wq_pop     = wb_fire && t_q.ooo && rq_empty;

    assign cls_dec[CLS_READ]  = wb_fire && op_is_read(wb_op);
    assign cls_dec[CLS_WRITE] = wb_fire && op_is_write(wb_op);

    // ---------------- mode and error state ----------------
    assign idle = !(|cls_nz) && rob_empty && rq_empty && wq_empty && !req_valid;

    always_comb begin
        t_d     = t_q;
        t_d.ooo = idle ? ooo_mode : t_q.ooo;
        if ((rob_mark && rob_miss) ||
            (rsp_fire && t_q.ooo && rsp_op == OP_FENCE) ||
            (|cls_under))
            t_d.err = 1'b1;
    end

    assign err = t_q.err;

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // ---------------- storage ----------------
    memreq_rob #(.DEPTH(ROB_DEPTH), .TAG_W(TAG_W)) u_rob (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (rob_alloc),
        .alloc_tag (req_tag),
        .alloc_op  (req_op),
        .mark      (rob_mark),
        .mark_tag  (rsp_tag),
        .retire    (rob_retire),
        .miss      (rob_miss),
        .full      (rob_full),
        .empty     (rob_empty),
        .head_done (rob_head_done),
        .head_tag  (rob_head_tag),
        .head_op   (rob_head_op)
    );

    memreq_retq #(.DEPTH(RET_DEPTH), .TAG_W(TAG_W)) u_rdq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rq_push),
        .push_tag (rsp_tag),
        .push_op  (rsp_op),
        .pop      (rq_pop),
        .full     (rq_full),
        .empty    (rq_empty),
        .head_tag (rq_head_tag),
        .head_op  (rq_head_op)
    );

    memreq_retq #(.DEPTH(RET_DEPTH), .TAG_W(TAG_W)) u_wrq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wq_push),
        .push_tag (rsp_tag),
        .push_op  (rsp_op),
        .pop      (wq_pop),
        .full     (wq_full),
        .empty    (wq_empty),
        .head_tag (wq_head_tag),
        .head_op  (wq_head_op)
    );

    // ---------------- assertions ----------------
    // R9: writeback is never offered without the register-file port
    assert_wb_needs_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> port_free);

    // R9: at most one structure releases an entry per cycle
    assert_one_completion_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rq_pop, wq_pop, rob_retire}));

    // R6: the error flag is sticky
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R10: the delivery mode holds while work is outstanding
    assert_mode_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(t_q.ooo));

    // R4: the reorder queue cannot run out while budget remains
    assert_rob_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rob_full |-> !(cls_room[CLS_READ] || cls_room[CLS_WRITE]));

endmodule

// File: tb/memreq_tracker_test.sv
module memreq_tracker_test;
    localparam int TAG_W     = 8;
    localparam int LIMIT     = 3;
    localparam int RET_DEPTH = 2;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, AT = 2'd2, FN = 2'd3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ooo_mode = 1'b0;
    logic             req_valid = 1'b0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [1:0]       req_op = LD;
    logic             req_ready;
    logic             iss_valid;
    logic [TAG_W-1:0] iss_tag;
    logic [1:0]       iss_op;
    logic             rsp_valid = 1'b0;
    logic [TAG_W-1:0] rsp_tag = '0;
    logic [1:0]       rsp_op = LD;
    logic             rsp_ready;
    logic             port_free = 1'b1;
    logic             wb_ready = 1'b0;
    logic             wb_valid;
    logic [TAG_W-1:0] wb_tag;
    logic [1:0]       wb_op;
    logic             err;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    memreq_tracker #(.TAG_W(TAG_W), .LIMIT(LIMIT), .RET_DEPTH(RET_DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .ooo_mode(ooo_mode),
        .req_valid(req_valid), .req_tag(req_tag), .req_op(req_op), .req_ready(req_ready),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_op(rsp_op), .rsp_ready(rsp_ready),
        .port_free(port_free), .wb_ready(wb_ready),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_op(wb_op), .err(err)
    );

    task automatic check(input string rq, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0; wb_ready = 1'b0; port_free = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic do_issue(input logic [1:0] op, input int tag);
        req_valid = 1'b1; req_op = op; req_tag = TAG_W'(tag);
        #1;
        check("R2 issue accepted", int'(req_ready), 1);
        check("R3 iss_valid", int'(iss_valid), 1);
        check("R3 iss_tag", int'(iss_tag), tag);
        check("R3 iss_op", int'(iss_op), int'(op));
        step();
        req_valid = 1'b0;
    endtask

    task automatic do_rsp(input logic [1:0] op, input int tag);
        rsp_valid = 1'b1; rsp_op = op; rsp_tag = TAG_W'(tag);
        step();
        rsp_valid = 1'b0;
    endtask

    task automatic take_wb(input string rq, input int tag, input logic [1:0] op);
        port_free = 1'b1; wb_ready = 1'b1;
        #1;
        check({rq, " wb_valid"}, int'(wb_valid), 1);
        check({rq, " wb_tag"}, int'(wb_tag), tag);
        check({rq, " wb_op"}, int'(wb_op), int'(op));
        step();
        wb_ready = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        ooo_mode = m;
        step();
        step();
    endtask

    task automatic t_reset();
        req_op = LD; rsp_op = LD;
        #1;
        check("R12 req_ready", int'(req_ready), 1);
        check("R12 rsp_ready", int'(rsp_ready), 1);
        check("R12 wb_valid", int'(wb_valid), 0);
        check("R12 err", int'(err), 0);
    endtask

    task automatic t_ordered();
        set_mode(1'b0);
        do_issue(LD, 1);
        do_issue(ST, 2);
        do_issue(FN, 3);
        do_issue(AT, 4);
        do_rsp(AT, 4);
        do_rsp(ST, 2);
        #1;
        check("R4 oldest not done, nothing offered", int'(wb_valid), 0);
        do_rsp(LD, 1);
        take_wb("R4 first", 1, LD);
        take_wb("R4 second", 2, ST);
        take_wb("R5 fence skipped", 4, AT);
        #1;
        check("R4 drained", int'(wb_valid), 0);
        check("R6 no error in clean run", int'(err), 0);
    endtask

    task automatic t_limit();
        set_mode(1'b0);
        do_issue(LD, 10);
        do_issue(AT, 11);
        do_issue(LD, 12);
        req_valid = 1'b1; req_op = LD; req_tag = 8'd13;
        #1;
        check("R2 load stalled at limit", int'(req_ready), 0);
        check("R2 no issue while stalled", int'(iss_valid), 0);
        step();
        check("R2 still stalled next cycle", int'(iss_valid), 0);
        req_op = AT;
        #1;
        check("R1 atomic shares load counter", int'(req_ready), 0);
        req_op = ST;
        #1;
        check("R1 store counter separate", int'(req_ready), 1);
        req_op = FN;
        #1;
        check("R2 fence not stalled", int'(req_ready), 1);
        req_valid = 1'b0;
        do_rsp(LD, 10);
        port_free = 1'b0; wb_ready = 1'b1;
        #1;
        check("R9 no writeback without port", int'(wb_valid), 0);
        step();
        check("R9 entry kept while port busy", int'(wb_valid), 0);
        wb_ready = 1'b0; port_free = 1'b1;
        take_wb("R9 after port frees", 10, LD);
        req_op = LD;
        #1;
        check("R9 completion returns budget", int'(req_ready), 1);
        do_rsp(LD, 12);
        do_rsp(AT, 11);
        take_wb("R4 drain", 11, AT);
        take_wb("R4 drain", 12, LD);
    endtask

    task automatic t_unknown_tag();
        set_mode(1'b0);
        do_rsp(LD, 99);
        check("R6 unmatched tag flags error", int'(err), 1);
        step();
        check("R6 error sticky", int'(err), 1);
        do_reset();
    endtask

    task automatic t_ooo();
        set_mode(1'b1);
        do_issue(ST, 20);
        do_issue(LD, 21);
        do_issue(AT, 22);
        do_rsp(ST, 20);
        do_rsp(LD, 21);
        do_rsp(AT, 22);
        take_wb("R7 load queue first", 21, LD);
        take_wb("R7 atomic on load path", 22, AT);
        take_wb("R7 store after loads", 20, ST);
        check("R11 clean ooo run", int'(err), 0);
    endtask

    task automatic t_full();
        set_mode(1'b1);
        do_issue(LD, 30);
        do_issue(LD, 31);
        do_issue(AT, 32);
        do_issue(ST, 33);
        do_rsp(LD, 30);
        do_rsp(LD, 31);
        rsp_op = AT; rsp_tag = 8'd32;
        #1;
        check("R8 load queue full blocks response", int'(rsp_ready), 0);
        rsp_op = ST;
        #1;
        check("R8 store queue still open", int'(rsp_ready), 1);
        do_rsp(ST, 33);
        take_wb("R7 in-order within queue", 30, LD);
        rsp_op = AT;
        #1;
        check("R8 room after pop", int'(rsp_ready), 1);
        do_rsp(AT, 32);
        take_wb("R7 queue order", 31, LD);
        take_wb("R7 queue order", 32, AT);
        take_wb("R7 store last", 33, ST);
    endtask

    task automatic t_mode_latch();
        set_mode(1'b1);
        do_issue(LD, 40);
        ooo_mode = 1'b0;
        step();
        do_issue(ST, 41);
        do_rsp(ST, 41);
        port_free = 1'b1;
        #1;
        check("R10 mode held while busy", int'(wb_valid), 1);
        take_wb("R10 store passes load", 41, ST);
        do_rsp(LD, 40);
        take_wb("R10 drain", 40, LD);
        step();
        do_issue(LD, 50);
        do_issue(ST, 51);
        do_rsp(ST, 51);
        #1;
        check("R10 ordered after drain", int'(wb_valid), 0);
        do_rsp(LD, 50);
        take_wb("R10 ordered", 50, LD);
        take_wb("R10 ordered", 51, ST);
    endtask

    task automatic t_ooo_errors();
        set_mode(1'b1);
        do_rsp(ST, 60);
        take_wb("R11 stray store", 60, ST);
        check("R11 underflow flags error", int'(err), 1);
        do_reset();
        check("R12 reset clears error", int'(err), 0);
        set_mode(1'b1);
        do_rsp(FN, 61);
        check("R11 fence response flags error", int'(err), 1);
        do_reset();
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ordered();
        t_limit();
        t_unknown_tag();
        t_ooo();
        t_full();
        t_mode_latch();
        t_ooo_errors();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule